// File: doc/BRIEF.md
# Dual-Processor Doorbell Interrupt Unit

This block lets two processors raise interrupts at each other through a shared 4 KB register window on a 32-bit APB-style bus. Every processor owns a small pending register of doorbell bits. Any agent on the bus can ring a doorbell by writing ones to that processor's set address, and the receiver acknowledges by writing ones to its clear address. A status address shows the current pending bits. The processor's interrupt line stays high for as long as any of its pending bits is set.

The top of the window holds read-only identification words. All other offsets are reserved. Accesses that the block cannot honour complete normally but return an error response. Such accesses include reading a write-only port, writing a read-only word, reaching a reserved or misaligned offset, and a partial-width write. None of them changes any state.

Top module: `dbell_unit`

## Requirements
- R1: After reset every pending register is zero, every `irq_o` bit is low and both status words read as zero.
- R2: A legal write to a processor's set address (0x004 for processor 0, 0x014 for processor 1) ORs `pwdata[3:0]` into that processor's pending bits. Bits 31:4 of the data are discarded.
- R3: A legal write to a processor's clear address (0x008 / 0x018) clears each pending bit whose position in `pwdata[3:0]` holds a one. Other pending bits keep their values.
- R4: `irq_o[n]` is high exactly when processor n's pending bits are nonzero. It follows a write from the first cycle after the access phase and changes at no other time.
- R5: Reading a status address (0x000 / 0x010) returns the pending bits in bits 3:0 and zero in bits 31:4. A read in the transfer after a write sees the written result.
- R6: Reading a set or clear address returns zero and raises `pslverr`.
- R7: Writing a status address or an identification word changes nothing and raises `pslverr`.
- R8: The words at 0xFD0, 0xFD4, ..., 0xFFC read, in rising address order, 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with no error.
- R9: Any other offset, and any offset with `paddr[1:0]` nonzero, reads as zero, ignores writes and raises `pslverr`.
- R10: A write whose `pstrb` is not 4'b1111 is ignored and raises `pslverr`, even at a set or clear address.
- R11: `pready` is high in every access phase. `pslverr` is high only in an access phase, and only for the illegal cases above.
- R12: Writes to one processor's set or clear address never change the other processor's pending bits or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte lane enables for writes |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete (always one) |
| pslverr | output | 1 | Error response for an illegal access |
| irq_o | output | 2 | Per-processor doorbell interrupt |

## Verification
Directed sequences first set data that has garbage in the upper bits, then clear single bits, then clear all bits. These show whether masking, OR-accumulation and selective clearing are each implemented, rather than plain overwrite. A randomized mix then sends reads and writes of either direction to status, set, clear, identification, reserved and misaligned offsets, some with partial strobes. A reference model predicts the data, error and interrupts for each transfer, so a swapped address decode, a leaked write or a misplaced error shows up as a mismatch. Alternating traffic between the two processors separates per-processor state from shared state.

// File: rtl/dbell_pkg.sv
`timescale 1ns/1ps
package dbell_pkg;

   localparam int WIN_AW   = 12;
   localparam int ID_WORDS = 12;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_STAT,
      RG_SET,
      RG_CLR,
      RG_ID
   } region_e;

   function automatic logic [7:0] id_byte(input logic [3:0] idx);
      case (idx)
         4'd0:    id_byte = 8'h04;
         4'd4:    id_byte = 8'h56;
         4'd5:    id_byte = 8'hB8;
         4'd6:    id_byte = 8'h0B;
         4'd8:    id_byte = 8'h0D;
         4'd9:    id_byte = 8'hF0;
         4'd10:   id_byte = 8'h05;
         4'd11:   id_byte = 8'hB1;
         default: id_byte = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/dbell_decode.sv
`timescale 1ns/1ps
module dbell_decode
   import dbell_pkg::*;
#(
   parameter int NUM_CORES = 2
) (
   input  logic [WIN_AW-1:0]    addr,
   output region_e              region,
   output logic [NUM_CORES-1:0] core_hit,
   output logic [3:0]           id_idx
);

   logic aligned;
   logic in_id;
   logic any_core;

   assign aligned = (addr[1:0] == 2'b00);
   assign in_id   = addr[11:4] >= 8'hFD;

   genvar c;
   generate
      for (c = 0; c < NUM_CORES; c++) begin : g_hit
         assign core_hit[c] = (addr[11:4] == 8'(c));
      end
   endgenerate

   assign any_core = |core_hit;

   // index 0 at 0xFD0: group from addr[5:4] (D->0, E->1, F->2), word from addr[3:2]
   assign id_idx = {addr[5:4] - 2'd1, addr[3:2]};

   always_comb begin
      region = RG_NONE;
      if (aligned) begin
         if (in_id) begin
            region = RG_ID;
         end else if (any_core) begin
            case (addr[3:2])
               2'd0:    region = RG_STAT;
               2'd1:    region = RG_SET;
               2'd2:    region = RG_CLR;
               default: region = RG_NONE;
            endcase
         end
      end
   end

endmodule

// File: rtl/dbell_pend_reg.sv
`timescale 1ns/1ps
module dbell_pend_reg #(
   parameter int PEND_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [PEND_W-1:0] bits,
   output logic [PEND_W-1:0] pend,
   output logic              irq
);

   logic [PEND_W-1:0] pend_q;
   logic [PEND_W-1:0] pend_d;

   always_comb begin
      pend_d = pend_q;
      if (set_en) pend_d = pend_q | bits;
      if (clr_en) pend_d = pend_q & ~bits;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign pend = pend_q;
   assign irq  = |pend_q;

endmodule

// File: rtl/dbell_id_rom.sv
`timescale 1ns/1ps
module dbell_id_rom
   import dbell_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [3:0]        idx,
   output logic [DATA_W-1:0] word
);

   assign word = {{(DATA_W-8){1'b0}}, id_byte(idx)};

endmodule

// File: rtl/dbell_unit.sv
`timescale 1ns/1ps
module dbell_unit
   import dbell_pkg::*;
#(
   parameter int NUM_CORES = 2,
   parameter int PEND_W    = 4,
   parameter int DATA_W    = 32
) (
   input  logic                  pclk,
   input  logic                  presetn,
   input  logic                  psel,
   input  logic                  penable,
   input  logic                  pwrite,
   input  logic [WIN_AW-1:0]     paddr,
   input  logic [DATA_W-1:0]     pwdata,
   input  logic [DATA_W/8-1:0]   pstrb,
   output logic [DATA_W-1:0]     prdata,
   output logic                  pready,
   output logic                  pslverr,
   output logic [NUM_CORES-1:0]  irq_o
);

   localparam int STRB_W    = DATA_W / 8;
   localparam int CORE_SPAN = NUM_CORES * 16;

   generate
      if (PEND_W < 1 || PEND_W > 8) begin : g_bad_pend
         $error("dbell_unit: PEND_W must lie in 1..8");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("dbell_unit: DATA_W must be 32");
      end
      if (NUM_CORES < 1 || CORE_SPAN > 'hFD0) begin : g_bad_cores
         $error("dbell_unit: NUM_CORES overlaps the identification words");
      end
   endgenerate

   region_e                         region;
   logic [NUM_CORES-1:0]            core_hit;
   logic [3:0]                      id_idx;
   logic [DATA_W-1:0]               id_word;
   logic [NUM_CORES-1:0][PEND_W-1:0] pend_all;
   logic [PEND_W-1:0]               stat_sel;
   logic                            acc;
   logic                            full_strb;
   logic                            wr_ok;
   logic                            illegal;
   logic                            unused_hi;

   assign unused_hi = ^pwdata[DATA_W-1:PEND_W];

   dbell_decode #(.NUM_CORES(NUM_CORES)) u_dec (
      .addr     (paddr),
      .region   (region),
      .core_hit (core_hit),
      .id_idx   (id_idx)
   );

   dbell_id_rom #(.DATA_W(DATA_W)) u_id (
      .idx  (id_idx),
      .word (id_word)
   );

   assign acc       = psel & penable;
   assign full_strb = (pstrb == {STRB_W{1'b1}});
   assign wr_ok     = acc & pwrite & full_strb;

   genvar c;
   generate
      for (c = 0; c < NUM_CORES; c++) begin : g_core
         logic set_en;
         logic clr_en;
         assign set_en = wr_ok & core_hit[c] & (region == RG_SET);
         assign clr_en = wr_ok & core_hit[c] & (region == RG_CLR);
         dbell_pend_reg #(.PEND_W(PEND_W)) u_pend (
            .clk    (pclk),
            .rst_n  (presetn),
            .set_en (set_en),
            .clr_en (clr_en),
            .bits   (pwdata[PEND_W-1:0]),
            .pend   (pend_all[c]),
            .irq    (irq_o[c])
         );
      end
   endgenerate

   always_comb begin
      stat_sel = '0;
      for (int k = 0; k < NUM_CORES; k++) begin
         if (core_hit[k]) stat_sel = stat_sel | pend_all[k];
      end
   end

   always_comb begin
      prdata = '0;
      if (acc && !pwrite) begin
         case (region)
            RG_STAT: prdata = {{(DATA_W-PEND_W){1'b0}}, stat_sel};
            RG_ID:   prdata = id_word;
            default: prdata = '0;
         endcase
      end
   end

   always_comb begin
      case (region)
         RG_STAT, RG_ID: illegal = pwrite;
         RG_SET, RG_CLR: illegal = !pwrite || !full_strb;
         default:        illegal = 1'b1;
      endcase
   end

   assign pslverr = acc & illegal;
   assign pready  = 1'b1;

endmodule

// File: rtl/dbell_unit_chk.sv
`timescale 1ns/1ps
module dbell_unit_chk #(
   parameter int NUM_CORES = 2,
   parameter int PEND_W    = 4,
   parameter int DATA_W    = 32
) (
   input logic                 pclk,
   input logic                 presetn,
   input logic                 psel,
   input logic                 penable,
   input logic                 pwrite,
   input logic [11:0]          paddr,
   input logic [DATA_W-1:0]    pwdata,
   input logic [DATA_W/8-1:0]  pstrb,
   input logic [DATA_W-1:0]    prdata,
   input logic                 pready,
   input logic                 pslverr,
   input logic [NUM_CORES-1:0] irq_o
);

   logic acc;
   logic full_wr;
   logic unused_chk;

   assign acc        = psel && penable;
   assign full_wr    = acc && pwrite && (pstrb == {(DATA_W/8){1'b1}});
   assign unused_chk = ^pwdata[DATA_W-1:PEND_W];

   // R11: every access phase completes at once
   assert_ready_R11: assert property (@(posedge pclk) disable iff (!presetn)
      acc |-> pready);

   // R11: the error response appears only inside an access phase
   assert_err_phase_R11: assert property (@(posedge pclk) disable iff (!presetn)
      pslverr |-> acc);

   // R7, R9, R10: a flagged access leaves the interrupts untouched
   assert_illegal_stable_R7: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pslverr) |=> $stable(irq_o));

   // R4: interrupts move only after an access phase
   assert_idle_stable_R4: assert property (@(posedge pclk) disable iff (!presetn)
      !acc |=> $stable(irq_o));

   // R6: reading processor 0's write-only ports yields zero with an error
   assert_wo_read_R6: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && !pwrite && (paddr == 12'h004 || paddr == 12'h008)) |-> (prdata == '0 && pslverr));

   // R2: a nonzero set to processor 0 raises its interrupt
   assert_set_raise_R2: assert property (@(posedge pclk) disable iff (!presetn)
      (full_wr && paddr == 12'h004 && pwdata[PEND_W-1:0] != '0) |=> irq_o[0]);

   // R3: clearing all bits of processor 0 drops its interrupt
   assert_clr_all_R3: assert property (@(posedge pclk) disable iff (!presetn)
      (full_wr && paddr == 12'h008 && pwdata[PEND_W-1:0] == {PEND_W{1'b1}}) |=> !irq_o[0]);

endmodule

bind dbell_unit dbell_unit_chk #(
   .NUM_CORES (NUM_CORES),
   .PEND_W    (PEND_W),
   .DATA_W    (DATA_W)
) u_chk (
   .pclk    (pclk),
   .presetn (presetn),
   .psel    (psel),
   .penable (penable),
   .pwrite  (pwrite),
   .paddr   (paddr),
   .pwdata  (pwdata),
   .pstrb   (pstrb),
   .prdata  (prdata),
   .pready  (pready),
   .pslverr (pslverr),
   .irq_o   (irq_o)
);

// File: tb/dbell_unit_tb_top.sv
`timescale 1ns/1ps
module dbell_unit_tb_top;

   logic        clk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [3:0]  pstrb = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        pslverr;
   logic [1:0]  irq_o;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;
   logic [3:0] mdl [2];

   always #4 clk = ~clk;

   dbell_unit dut_i (
      .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
      .prdata(prdata), .pready(pready), .pslverr(pslverr), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // 0 none, 1 status, 2 set, 3 clear, 4 id
   function automatic int cls(input logic [11:0] a);
      if (a[1:0] != 0) return 0;
      if (a >= 12'hFD0) return 4;
      if (a[11:4] > 1) return 0;
      case (a[3:0])
         4'h0: return 1;
         4'h4: return 2;
         4'h8: return 3;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] id_val(input int i);
      logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                             8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      return {24'h0, t[i]};
   endfunction

   function automatic bit exp_err(input logic [11:0] a, input bit wr, input logic [3:0] s);
      int r = cls(a);
      if (r == 0) return 1;
      if (wr) return (r == 1 || r == 4 || s != 4'hF);
      return (r == 2 || r == 3);
   endfunction

   function automatic logic [31:0] exp_rd(input logic [11:0] a, input bit wr);
      int r = cls(a);
      if (wr) return 0;
      if (r == 1) return {28'h0, mdl[a[4]]};
      if (r == 4) return id_val(int'((a - 12'hFD0) >> 2));
      return 0;
   endfunction

   function automatic string req_of(input logic [11:0] a, input bit wr, input logic [3:0] s);
      int r = cls(a);
      if (r == 0) return "R9";
      if (wr && s != 4'hF) return "R10";
      if (r == 4) return wr ? "R7" : "R8";
      if (r == 1) return wr ? "R7" : "R5";
      if (!wr) return "R6";
      return (r == 2) ? "R2" : "R3";
   endfunction

   task automatic xfer(input logic [11:0] a, input bit wr, input logic [31:0] d,
                       input logic [3:0] s, output logic [31:0] rd, output logic er,
                       output logic rdy);
      @(negedge clk);
      psel = 1; penable = 0; paddr = a; pwrite = wr; pwdata = d; pstrb = s;
      @(negedge clk);
      penable = 1;
      #1;
      rd = prdata; er = pslverr; rdy = pready;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic op(input logic [11:0] a, input bit wr, input logic [31:0] d, input logic [3:0] s);
      logic [31:0] rd;
      logic er, rdy;
      string rq = req_of(a, wr, s);
      logic [31:0] erd = exp_rd(a, wr);
      bit eer = exp_err(a, wr, s);
      xfer(a, wr, d, s, rd, er, rdy);
      check({rq, " rdata"}, rd, erd);
      check({rq, " R11 err"}, {31'h0, er}, {31'h0, eer});
      check("R11 ready", {31'h0, rdy}, 32'h1);
      if (wr && !eer) begin
         if (cls(a) == 2) mdl[a[4]] = mdl[a[4]] | d[3:0];
         else             mdl[a[4]] = mdl[a[4]] & ~d[3:0];
      end
      check({rq, " R4 R12 irq"}, {30'h0, irq_o},
            {30'h0, (mdl[1] != 0), (mdl[0] != 0)});
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [11:0] a;
      logic [3:0]  s;
      bit          wr;
      int          k;
      void'($urandom(32'h5EED));
      mdl[0] = 0; mdl[1] = 0;
      repeat (4) @(negedge clk);
      check("R1 irq at reset", {30'h0, irq_o}, 32'h0);
      presetn = 1;
      check("R11 no err idle", {31'h0, pslverr}, 32'h0);
      op(12'h000, 0, 0, 4'hF);                     // R1 status zero
      op(12'h010, 0, 0, 4'hF);                     // R1 status zero
      for (int i = 0; i < 12; i++) op(12'hFD0 + 12'(4 * i), 0, 0, 4'hF); // R8
      op(12'h004, 1, 32'hFFFF_FFF5, 4'hF);         // R2 upper bits discarded
      op(12'h000, 0, 0, 4'hF);                     // R5 reads 5
      op(12'h004, 1, 32'h2, 4'hF);                 // R2 accumulates to 7
      op(12'h008, 1, 32'h1, 4'hF);                 // R3 leaves 6
      op(12'h000, 0, 0, 4'hF);
      op(12'h004, 0, 0, 4'hF);                     // R6
      op(12'h018, 0, 0, 4'hF);                     // R6
      op(12'h000, 1, 32'hF, 4'hF);                 // R7 status write ignored
      op(12'hFE0, 1, 32'hF, 4'hF);                 // R7 id write ignored
      op(12'h100, 1, 32'hF, 4'hF);                 // R9 unmapped
      op(12'h00C, 0, 0, 4'hF);                     // R9
      op(12'h006, 1, 32'hF, 4'hF);                 // R9 misaligned
      op(12'h014, 1, 32'hF, 4'h7);                 // R10 partial strobe
      op(12'h014, 1, 32'h9, 4'hF);                 // R12 processor 1 only
      op(12'h000, 0, 0, 4'hF);
      op(12'h008, 1, 32'hF, 4'hF);                 // R3 clear all
      op(12'h010, 0, 0, 4'hF);                     // R12 processor 1 kept
      for (int i = 0; i < 400; i++) begin
         k = int'($urandom % 10);
         case (k)
            0, 1, 2, 3, 4, 5: a = 12'((k / 3) * 16 + (k % 3) * 4);
            6: a = 12'hFD0 + 12'(4 * ($urandom % 12));
            7: a = 12'h020 + 12'(4 * ($urandom % 996));
            8: a = 12'h004 + 12'($urandom % 3 + 1);
            default: a = ($urandom % 2) ? 12'h01C : 12'h00C;
         endcase
         wr = ($urandom % 3) != 0;
         s  = (($urandom % 5) == 0) ? 4'($urandom % 15) : 4'hF;
         op(a, wr, $urandom, s);
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule